// File: doc/BRIEF.md
# Watchdog Timer Peripheral

This block is a watchdog timer sitting on a simple 32-bit register bus. A one-microsecond tick input feeds a programmable prescaler. The prescaler emits a slower count tick, and each count tick decrements a reloadable down-counter. Software programs a timeout and a divisor, sets the enable bit, and must then kick the watchdog at regular intervals. If the counter runs out while enabled, the block raises a one-clock system reset request. It also records the event in a sticky cause flag.

Two resets feed the block. The power-on reset clears everything. The system reset, which the chip issues in answer to the watchdog request, clears the timer, control and load state but leaves the cause flag intact. Boot software can therefore read the cause flag afterwards to learn why the chip restarted.

To reprogram a running watchdog, software clears the enable bit, writes the new divisor and load value, and sets enable again. Counting is frozen while enable is low, so this sequence produces no spurious request.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset, reads of offsets 0x00, 0x20, 0x24 and 0x38 all return zero, and reset_req is low.
- R2: The control register is at offset 0x20. Bits [31:16] hold the prescaler divisor and bit 7 is the enable bit. A read returns exactly those fields, and every other bit reads as zero.
- R3: The load register is at offset 0x24 and keeps only bits [15:0] of a write. It reads back zero-extended.
- R4: Take divisor D and load L, with us_tick high on every clock. After the clock edge that sets enable, reset_req first goes high right after edge max(D,1)*max(L,1). A divisor of 0 acts as 1, and a load of 0 acts as 1.
- R5: Each expiry drives reset_req high for a single clock and reloads the counter. The next expiry therefore follows one full period later.
- R6: Bit 1 of offset 0x38 is the cause flag, and it is set on the clock after an expiry. Writing 1 to bit 1 clears it, and writing 0 has no effect. Apart from that write, only por_rst clears it.
- R7: Writing the status register (offset 0x00) with bit 9 set reloads the counter and restarts the prescaler, so a full period starts over. Status writes with bit 9 clear do nothing. The status register reads as zero.
- R8: While enable is clear, the counter and prescaler hold their values and no request is raised. Setting enable from 0 to 1 reloads both, so the first timeout is a full period.
- R9: A write to the load register does not alter the countdown already in progress. The new value is used at the next reload, whether that comes from a kick, an enable or an expiry.
- R10: Reads of unmapped offsets return zero. Read data appears on the clock after the read strobe.
- R11: sys_rst clears the control register, the load register, the counter and the prescaler, but leaves the cause flag unchanged.
- R12: The prescaler advances only on clocks where us_tick is high. With us_tick held low, no request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high; clears all state |
| sys_rst | input | 1 | System reset, synchronous, active high; keeps the cause flag |
| us_tick | input | 1 | One-clock pulse every microsecond |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the clock after bus_re |
| reset_req | output | 1 | One-clock system reset request on expiry |

## Verification
The assertions check several rules on every cycle:
- a request only ever follows a count tick while the watchdog is enabled;
- the cause flag is set after every request and stays set until it is cleared;
- the counter and prescaler hold still while disabled, and a reload takes the load value.

The exact timeout arithmetic needs the bench's scenarios, which sweep the divisor and load values. Those scenarios also show that kicks prevent expiry, that load writes are deferred to the next reload, that the cause flag survives a system reset, and that unmapped offsets and the status register read as zero.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int DIV_W    = 16;
    localparam int CNT_W    = 16;

    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_CAUSE = 8'h38;

    localparam int EN_BIT    = 7;
    localparam int KICK_BIT  = 9;
    localparam int CAUSE_BIT = 1;
    localparam int DIV_LSB   = 16;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             en;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_CTRL,
        SEL_LOAD,
        SEL_CAUSE
    } sel_e;

    function automatic sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_STAT:  return SEL_STAT;
            OFS_CTRL:  return SEL_CTRL;
            OFS_LOAD:  return SEL_LOAD;
            OFS_CAUSE: return SEL_CAUSE;
            default:   return SEL_NONE;
        endcase
    endfunction

    // last prescaler phase; a divisor of zero behaves as one
    function automatic logic [DIV_W-1:0] last_phase(input logic [DIV_W-1:0] d);
        return (d == '0) ? '0 : d - 1'b1;
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int DIV_W = wdog_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic             us_tick,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] last;
    logic             at_end;

    assign last   = wdog_pkg::last_phase(div);
    assign at_end = (phase_q >= last);
    assign tick   = run && us_tick && at_end;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (run && us_tick) begin
            phase_q <= at_end ? '0 : phase_q + 1'b1;
        end
    end

    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(phase_q)) else $error("prescaler moved while stopped"); // R8

    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase_q == '0)) else $error("prescaler not restarted"); // R7

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int CNT_W = wdog_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             last_tick;

    assign last_tick = (cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (restart) begin
                cnt_q <= reload_val;
            end else if (tick) begin
                if (last_tick) begin
                    cnt_q  <= reload_val;
                    expire <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    AST_RELOAD_TAKES_LOAD: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == $past(reload_val))) else $error("reload mismatch"); // R7

    AST_EXPIRE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        expire |-> $past(tick)) else $error("expiry without count tick"); // R4

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(cnt_q)) else $error("counter moved without tick"); // R12

endmodule

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int A_W = wdog_pkg::ADDR_W,
    parameter int D_W = wdog_pkg::DATA_W,
    parameter int V_W = wdog_pkg::DIV_W,
    parameter int C_W = wdog_pkg::CNT_W
) (
    input  logic           clk,
    input  logic           por_rst,
    input  logic           sys_rst,
    input  logic [A_W-1:0] bus_addr,
    input  logic           bus_we,
    input  logic [D_W-1:0] bus_wdata,
    input  logic           bus_re,
    output logic [D_W-1:0] bus_rdata,
    input  logic           expire,
    output logic           run,
    output logic [V_W-1:0] div,
    output logic [C_W-1:0] load,
    output logic           restart
);
    ctrl_t          ctrl_q;
    logic [C_W-1:0] load_q;
    logic           cause_q;
    sel_e           sel;
    logic           rst_any;
    logic           wr_ctrl, wr_load, wr_stat, wr_cause;
    logic           kick, start, clr_cause;
    logic [D_W-1:0] rd_mux;

    assign rst_any   = por_rst || sys_rst;
    assign sel       = decode_addr(bus_addr);
    assign wr_ctrl   = bus_we && (sel == SEL_CTRL);
    assign wr_load   = bus_we && (sel == SEL_LOAD);
    assign wr_stat   = bus_we && (sel == SEL_STAT);
    assign wr_cause  = bus_we && (sel == SEL_CAUSE);
    assign kick      = wr_stat && bus_wdata[KICK_BIT];
    assign start     = wr_ctrl && bus_wdata[EN_BIT] && !ctrl_q.en;
    assign clr_cause = wr_cause && bus_wdata[CAUSE_BIT];

    assign restart = kick || start;
    assign run     = ctrl_q.en;
    assign div     = ctrl_q.div;
    assign load    = load_q;

    always_ff @(posedge clk) begin
        if (rst_any) begin
            ctrl_q <= '0;
            load_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.div <= bus_wdata[DIV_LSB +: V_W];
                ctrl_q.en  <= bus_wdata[EN_BIT];
            end
            if (wr_load) begin
                load_q <= bus_wdata[C_W-1:0];
            end
        end
    end

    // cause flag lives on the power-on reset only
    always_ff @(posedge clk) begin
        if (por_rst) begin
            cause_q <= 1'b0;
        end else if (expire) begin
            cause_q <= 1'b1;
        end else if (clr_cause) begin
            cause_q <= 1'b0;
        end
    end

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_CTRL: begin
                rd_mux[DIV_LSB +: V_W] = ctrl_q.div;
                rd_mux[EN_BIT]         = ctrl_q.en;
            end
            SEL_LOAD:  rd_mux[C_W-1:0]   = load_q;
            SEL_CAUSE: rd_mux[CAUSE_BIT] = cause_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst_any) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            bus_rdata <= rd_mux;
        end
    end

    AST_CAUSE_SET: assert property (@(posedge clk) disable iff (por_rst)
        expire |=> cause_q) else $error("cause not recorded"); // R6

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (por_rst)
        (cause_q && !clr_cause) |=> cause_q) else $error("cause lost"); // R6

    AST_LOAD_STABLE: assert property (@(posedge clk) disable iff (rst_any)
        !wr_load |=> $stable(load_q)) else $error("load changed without write"); // R9

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int ADDR_W = wdog_pkg::ADDR_W,
    parameter int DATA_W = wdog_pkg::DATA_W,
    parameter int DIV_W  = wdog_pkg::DIV_W,
    parameter int CNT_W  = wdog_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              sys_rst,
    input  logic              us_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reset_req
);
    logic             rst_any;
    logic             run;
    logic             restart;
    logic             tick;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] load;

    assign rst_any = por_rst || sys_rst;

    wdog_regfile #(
        .A_W(ADDR_W), .D_W(DATA_W), .V_W(DIV_W), .C_W(CNT_W)
    ) u_regs (
        .clk       (clk),
        .por_rst   (por_rst),
        .sys_rst   (sys_rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .expire    (reset_req),
        .run       (run),
        .div       (div),
        .load      (load),
        .restart   (restart)
    );

    wdog_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst     (rst_any),
        .restart (restart),
        .run     (run),
        .us_tick (us_tick),
        .div     (div),
        .tick    (tick)
    );

    wdog_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst_any),
        .restart    (restart),
        .tick       (tick),
        .reload_val (load),
        .expire     (reset_req)
    );

    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst_any)
        reset_req |-> $past(run)) else $error("request while disabled"); // R8

    AST_REQ_NEEDS_US: assert property (@(posedge clk) disable iff (rst_any)
        reset_req |-> $past(us_tick)) else $error("request without us tick"); // R12

endmodule

// File: tb/wdog_timer_test.sv
`timescale 1ns/1ps
module wdog_timer_test;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        sys_rst = 1'b0;
    logic        us_tick = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        reset_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int req_count = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wdog_timer uut (
        .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst), .us_tick(us_tick),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_re(bus_re), .bus_rdata(bus_rdata), .reset_req(reset_req)
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (reset_req) req_count <= req_count + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_sys;
        @(negedge clk); sys_rst = 1'b1;
        @(negedge clk); sys_rst = 1'b0;
    endtask

    task automatic pulse_por;
        @(negedge clk); por_rst = 1'b1;
        @(negedge clk); por_rst = 1'b0;
    endtask

    task automatic wait_req(input int limit, output int stamp);
        stamp = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (reset_req) begin
                stamp = cyc;
                break;
            end
        end
    endtask

    initial begin
        logic [31:0] v;
        int base, s1, s2, t, snap;

        repeat (3) @(negedge clk);
        por_rst = 1'b0;

        // R1 reset state
        chk(reset_req == 1'b0, "R1 reset_req", int'(reset_req), 0);
        rd(8'h00, v); chk(v == 0, "R1 status", v, 0);
        rd(8'h20, v); chk(v == 0, "R1 control", v, 0);
        rd(8'h24, v); chk(v == 0, "R1 load", v, 0);
        rd(8'h38, v); chk(v == 0, "R1 cause", v, 0);

        // R10 unmapped offsets
        rd(8'h10, v); chk(v == 0, "R10 offset 0x10", v, 0);
        rd(8'h3C, v); chk(v == 0, "R10 offset 0x3C", v, 0);
        rd(8'h04, v); chk(v == 0, "R10 offset 0x04", v, 0);

        // R3 load width
        wr(8'h24, 32'hABCD_1234);
        rd(8'h24, v); chk(v == 32'h0000_1234, "R3 load readback", v, 32'h1234);

        // R2 control fields
        wr(8'h20, 32'h03E8_FFFF);
        rd(8'h20, v); chk(v == 32'h03E8_0080, "R2 control readback", v, 32'h03E8_0080);

        // R11 system reset clears control and load
        pulse_sys;
        rd(8'h20, v); chk(v == 0, "R11 control cleared", v, 0);
        rd(8'h24, v); chk(v == 0, "R11 load cleared", v, 0);

        // R4 / R5 sweep of divisor and load
        for (int n = 0; n < 4; n++) begin
            for (int l = 0; l < 5; l++) begin
                t = ((n == 0) ? 1 : n) * ((l == 0) ? 1 : l);
                pulse_sys;
                wr(8'h24, l);
                wr(8'h20, (n << 16) | 32'h80);
                base = cyc;
                wait_req(200, s1);
                chk(s1 - base == t, "R4 first timeout", s1 - base, t);
                if (t > 1) begin
                    @(negedge clk);
                    chk(reset_req == 1'b0, "R5 one clock pulse", int'(reset_req), 0);
                end
                wait_req(200, s2);
                chk(s2 - s1 == t, "R5 reload period", s2 - s1, t);
            end
        end
        pulse_sys;

        // R6 / R11 cause survives system reset, write-one-to-clear
        rd(8'h38, v); chk(v == 32'h2, "R6 cause after sys_rst (R11)", v, 2);
        wr(8'h38, 32'h0);
        rd(8'h38, v); chk(v == 32'h2, "R6 write 0 no effect", v, 2);
        wr(8'h38, 32'h2);
        rd(8'h38, v); chk(v == 32'h0, "R6 write 1 clears", v, 0);

        // R7 kicks prevent expiry, bit 9 only
        pulse_sys;
        wr(8'h24, 5);
        wr(8'h20, 32'h0002_0080);
        snap = req_count;
        for (int k = 0; k < 6; k++) begin
            repeat (4) @(negedge clk);
            wr(8'h00, 32'h0000_0200);
        end
        base = cyc;
        chk(req_count == snap, "R7 kicks hold off", req_count - snap, 0);
        repeat (3) @(negedge clk);
        wr(8'h00, 32'hFFFF_FDFF);
        wait_req(200, s1);
        chk(s1 - base == 10, "R7 timeout after last kick", s1 - base, 10);
        rd(8'h00, v); chk(v == 0, "R7 status reads zero", v, 0);

        // R9 load write deferred
        pulse_sys;
        wr(8'h24, 8);
        wr(8'h20, 32'h0001_0080);
        base = cyc;
        wr(8'h24, 3);
        wait_req(200, s1);
        chk(s1 - base == 8, "R9 current count kept", s1 - base, 8);
        wait_req(200, s2);
        chk(s2 - s1 == 3, "R9 new load at reload", s2 - s1, 3);

        // R8 disable freezes, re-enable is fresh
        pulse_sys;
        wr(8'h24, 20);
        wr(8'h20, 32'h0001_0080);
        repeat (5) @(negedge clk);
        wr(8'h20, 32'h0001_0000);
        snap = req_count;
        repeat (60) @(negedge clk);
        chk(req_count == snap, "R8 no request while disabled", req_count - snap, 0);
        rd(8'h20, v); chk(v == 32'h0001_0000, "R8 enable reads clear", v, 32'h0001_0000);
        wr(8'h20, 32'h0001_0080);
        base = cyc;
        wait_req(200, s1);
        chk(s1 - base == 20, "R8 full period after enable", s1 - base, 20);

        // R12 no counting without us_tick
        pulse_sys;
        us_tick = 1'b0;
        wr(8'h24, 2);
        wr(8'h20, 32'h0001_0080);
        snap = req_count;
        repeat (30) @(negedge clk);
        chk(req_count == snap, "R12 stalled without us_tick", req_count - snap, 0);
        us_tick = 1'b1;
        base = cyc;
        wait_req(50, s1);
        chk(s1 - base == 2, "R12 resumes with us_tick", s1 - base, 2);

        // R6 only power-on reset clears the flag otherwise
        pulse_sys;
        rd(8'h38, v); chk(v == 32'h2, "R6 cause set again", v, 2);
        pulse_por;
        rd(8'h38, v); chk(v == 0, "R6 cleared by por_rst", v, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule